// File: doc/BRIEF.md
# Clock-Synchronous Serial Master Receiver

This block is the receive half of a master-mode synchronous serial port. It drives the serial clock itself and shifts 8-bit frames in from a single data line, most significant bit first. Software controls it through a small register bus: a control register, a status register and a read-only receive data register. All three are reached with a 2-bit address and 16-bit data.

Reading the receive data register is what launches each frame, so software starts reception with a dummy read. Continuous reception then runs for as long as each byte is read out. A read made while a frame is still shifting is held and starts the next frame as soon as the current one ends, with no idle gap between them. A stop bit lets the current frame finish and then holds the clock idle. Clearing the enable bit before the last read ends the transfer, because that read then starts nothing.

A byte that completes while the previous one is still unread is dropped and raises a sticky overrun flag. While that flag is set, no frame can start.

Top module: `sync_rx_master`

## Requirements
- R1: After reset, the control, status and data registers all read 0, and with the polarity bit at 0 the serial clock output is low.
- R2: With the control register at address 0 holding enable (bit 0) = 1 and stop (bit 1) = 0, and overrun clear, a read of address 2 while idle starts a frame. Without such a read, the serial clock does not change.
- R3: A frame is 8 bits, MSB first. The polarity bit (control bit 2) sets the idle level of the serial clock, and data is sampled on the edge that leaves the idle level: rising when polarity is 0, falling when it is 1.
- R4: With divider = control bits 15:8, the clock period is 2×(divider+1) system cycles. The first sampling edge comes divider+1 cycles after the launching read edge, and the frame completes 16×(divider+1) cycles after that edge, with exactly 8 sampling edges.
- R5: Status bit 0 (receive-full) is set in the completion cycle, when the byte appears at address 2 bits 7:0. A read of address 2 clears it.
- R6: A read of address 2 during a frame makes the next frame start in the completion cycle, with busy staying 1.
- R7: While stop is 1, no new frame starts: a pending read is dropped and an idle read launches nothing.
- R8: While enable is 0, a read of address 2 returns the byte and clears receive-full, but starts no frame and produces no clock edge.
- R9: A frame that completes while receive-full is 1 sets status bit 1 (overrun). The new byte is discarded and address 2 keeps the unread byte.
- R10: While overrun is 1, no frame starts.
- R11: Overrun is cleared only by a write to address 1 with bit 1 = 0. Writing bit 1 = 1 leaves it set, and writes to address 2 change nothing.
- R12: Status bit 2 (busy) is 1 from the launching edge until the completion edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (side effects on address 2) |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data, combinational from address |
| sck_o | output | 1 | Serial clock output |
| sdi_i | input | 1 | Serial data input |

## Verification
Read data is combinational from the address, so the bench peeks it half a cycle after each edge. It uses the value for the state left by that edge. The first sampling edge is due divider+1 cycles after the launching read edge. Busy falls and receive-full rises exactly 16×(divider+1) edges after that read. The bench counts edges from the launch and compares them against these figures for several divider and polarity settings. It also counts every serial clock transition, to show that blocked reads (stop, disabled, overrun) produce none.

// File: rtl/sync_rx_pkg.sv
`timescale 1ns/1ps
package sync_rx_pkg;
  localparam int unsigned BUS_W  = 16;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DIV_W  = 8;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd2;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_STOP_BIT = 1;
  localparam int unsigned CTRL_POL_BIT  = 2;
  localparam int unsigned CTRL_DIV_LSB  = 8;

  localparam int unsigned STAT_FULL_BIT = 0;
  localparam int unsigned STAT_OVR_BIT  = 1;
  localparam int unsigned STAT_BUSY_BIT = 2;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             pol;
    logic             stop;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/srx_clk_gen.sv
`timescale 1ns/1ps
module srx_clk_gen
  import sync_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             phase_o,
  output logic             lead_o,
  output logic             trail_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             phase_q;
  logic             wrap;

  // >= keeps the half period bounded if the divider shrinks mid-frame
  assign wrap    = run_i && !restart_i && (cnt_q >= div_i);
  assign lead_o  = wrap && !phase_q;
  assign trail_o = wrap && phase_q;
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (run_i) begin
      if (wrap) begin
        cnt_q   <= '0;
        phase_q <= ~phase_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_idle_phase_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !restart_i) |-> !phase_q);
endmodule

// File: rtl/srx_shifter.sv
`timescale 1ns/1ps
module srx_shifter #(
  parameter int unsigned FRAME_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               lead_i,
  input  logic               sdi_i,
  output logic [FRAME_W-1:0] shreg_o,
  output logic               last_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_W + 1);

  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] shreg_q;

  assign shreg_o = shreg_q;
  assign last_o  = (cnt_q == CNT_W'(FRAME_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      shreg_q <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
    end else if (lead_i) begin
      shreg_q <= {shreg_q[FRAME_W-2:0], sdi_i};
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assert_no_extra_sample_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_i |-> (cnt_q < CNT_W'(FRAME_W)));
endmodule

// File: rtl/srx_regs.sv
`timescale 1ns/1ps
module srx_regs
  import sync_rx_pkg::*;
#(
  parameter int unsigned FRAME_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [BUS_W-1:0]   wdata_i,
  input  logic               done_i,
  input  logic               busy_i,
  input  logic [FRAME_W-1:0] rx_byte_i,
  output logic [BUS_W-1:0]   rdata_o,
  output logic               rd_data_o,
  output logic               ovr_hit_o,
  output ctrl_t              ctrl_o,
  output logic               ovr_o
);
  ctrl_t              ctrl_q;
  logic               full_q;
  logic               ovr_q;
  logic [FRAME_W-1:0] data_q;
  logic               wr_ctrl, wr_stat, ovr_clr;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign rd_data_o    = rd_i && (addr_i == ADDR_DATA);
  assign wr_ctrl      = wr_i && (addr_i == ADDR_CTRL);
  assign wr_stat      = wr_i && (addr_i == ADDR_STAT);
  assign ovr_clr      = wr_stat && !wdata_i[STAT_OVR_BIT];
  assign ovr_hit_o    = done_i && full_q && !rd_data_o;
  assign ctrl_o       = ctrl_q;
  assign ovr_o        = ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.div  <= wdata_i[CTRL_DIV_LSB +: DIV_W];
      ctrl_q.pol  <= wdata_i[CTRL_POL_BIT];
      ctrl_q.stop <= wdata_i[CTRL_STOP_BIT];
      ctrl_q.en   <= wdata_i[CTRL_EN_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else if (done_i && !ovr_hit_o) begin
      data_q <= rx_byte_i;
      full_q <= 1'b1;
    end else if (rd_data_o) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovr_q <= 1'b0;
    else if (ovr_hit_o) ovr_q <= 1'b1;
    else if (ovr_clr)   ovr_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: begin
        rdata_o[CTRL_DIV_LSB +: DIV_W] = ctrl_q.div;
        rdata_o[CTRL_POL_BIT]          = ctrl_q.pol;
        rdata_o[CTRL_STOP_BIT]         = ctrl_q.stop;
        rdata_o[CTRL_EN_BIT]           = ctrl_q.en;
      end
      ADDR_STAT: begin
        rdata_o[STAT_FULL_BIT] = full_q;
        rdata_o[STAT_OVR_BIT]  = ovr_q;
        rdata_o[STAT_BUSY_BIT] = busy_i;
      end
      ADDR_DATA: rdata_o[FRAME_W-1:0] = data_q;
      default:   rdata_o = '0;
    endcase
  end

  assert_full_on_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> full_q);
  assert_read_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o && !done_i) |=> !full_q);
  assert_overrun_keeps_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && full_q && !rd_data_o) |=> (ovr_q && $stable(data_q)));
  assert_overrun_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !ovr_clr) |=> ovr_q);
endmodule

// File: rtl/sync_rx_master.sv
`timescale 1ns/1ps
module sync_rx_master
  import sync_rx_pkg::*;
#(
  parameter int unsigned FRAME_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              sck_o,
  input  logic              sdi_i
);
  ctrl_t              ctrl;
  logic               ovr, ovr_hit, rd_data;
  logic               busy_q, pend_q;
  logic               can_go, launch, done, restart;
  logic               phase, lead, trail, last;
  logic [FRAME_W-1:0] shreg;

  assign can_go  = ctrl.en && !ctrl.stop && !ovr;
  assign launch  = rd_data && !busy_q && can_go;
  assign done    = trail && last;
  // a read landing in the completion cycle counts as pending
  assign restart = done && (pend_q || rd_data) && can_go && !ovr_hit;
  assign sck_o   = phase ^ ctrl.pol;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (launch)               busy_q <= 1'b1;
      else if (done && !restart) busy_q <= 1'b0;

      if (launch || done)           pend_q <= 1'b0;
      else if (rd_data && busy_q)   pend_q <= 1'b1;
    end
  end

  srx_regs #(.FRAME_W(FRAME_W)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_i      (wr_i),
    .rd_i      (rd_i),
    .wdata_i   (wdata_i),
    .done_i    (done),
    .busy_i    (busy_q),
    .rx_byte_i (shreg),
    .rdata_o   (rdata_o),
    .rd_data_o (rd_data),
    .ovr_hit_o (ovr_hit),
    .ctrl_o    (ctrl),
    .ovr_o     (ovr)
  );

  srx_clk_gen i_clk_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy_q),
    .restart_i (launch),
    .div_i     (ctrl.div),
    .phase_o   (phase),
    .lead_o    (lead),
    .trail_o   (trail)
  );

  srx_shifter #(.FRAME_W(FRAME_W)) i_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (launch || restart),
    .lead_i  (lead),
    .sdi_i   (sdi_i),
    .shreg_o (shreg),
    .last_o  (last)
  );

  assert_sck_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (sck_o == ctrl.pol));
  assert_stop_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && ctrl.stop) |=> !busy_q);
  assert_disabled_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !ctrl.en) |=> !busy_q);
  assert_overrun_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && ovr) |=> !busy_q);
  assert_busy_on_launch_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && !busy_q && ctrl.en && !ctrl.stop && !ovr) |=> busy_q);
endmodule

// File: tb/test_sync_rx_master.sv
`timescale 1ns/1ps
module test_sync_rx_master;
  localparam int PERIOD = 8;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;
  // {divider[7:0], polarity, 3'b0, byte[7:0]}
  localparam logic [19:0] VEC [6] = '{
    {8'd0, 1'b0, 3'b0, 8'hA5},
    {8'd1, 1'b0, 3'b0, 8'h3C},
    {8'd3, 1'b1, 3'b0, 8'h96},
    {8'd0, 1'b1, 3'b0, 8'h01},
    {8'd7, 1'b0, 3'b0, 8'h80},
    {8'd2, 1'b1, 3'b0, 8'hFF}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic        sck, sdi = 1'b0;

  int   checks = 0, errors = 0;
  time  t_edge = 0, t_launch = 0, first_lead_t = 0;
  // slave model state
  logic [7:0] tx_first = '0, tx_next = '0, tx_cur = '0;
  logic       load_tgl = 1'b0, load_seen = 1'b0, slave_on = 1'b0, pol_tb = 1'b0;
  int         bit_idx = 7, leads = 0, any_edges = 0;

  sync_rx_master i_sync_rx_master (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .sck_o(sck), .sdi_i(sdi)
  );

  always #(PERIOD/2) clk = ~clk;

  always @(sck or load_tgl) begin
    if (load_tgl != load_seen) begin
      load_seen = load_tgl;
      tx_cur    = tx_first;
      bit_idx   = 7;
      sdi       = tx_first[7];
    end else begin
      any_edges++;
      if (slave_on) begin
        if (sck != pol_tb) begin
          if (bit_idx == 7) first_lead_t = $time;
          leads++;
        end else begin
          if (bit_idx == 0) begin
            tx_cur  = tx_next;
            bit_idx = 7;
          end else begin
            bit_idx--;
          end
          sdi = tx_cur[bit_idx];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(posedge clk); t_edge = $time; #1 rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_idle(output int c);
    logic [15:0] s;
    c = 0;
    for (int k = 0; k < 5000; k++) begin
      peek(A_STAT, s);
      if (!s[2]) break;
      c++;
    end
  endtask

  task automatic wait_stat_bit(input int b);
    logic [15:0] s;
    for (int k = 0; k < 5000; k++) begin
      peek(A_STAT, s);
      if (s[b]) break;
    end
  endtask

  task automatic start_frame(input logic [7:0] b);
    logic [15:0] d;
    tx_first = b;
    load_tgl = ~load_tgl;
    slave_on = 1'b1;
    bus_rd(A_DATA, d);
    t_launch = t_edge;
  endtask

  initial begin
    int cycles = 0;
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", cycles, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d, s;
    int c, base;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    peek(A_CTRL, d); chk(d == 16'h0, "R1 ctrl", d, 0);
    peek(A_STAT, d); chk(d == 16'h0, "R1 status", d, 0);
    peek(A_DATA, d); chk(d == 16'h0, "R1 data", d, 0);
    chk(sck == 1'b0, "R1 sck", sck, 0);

    // R2 enable alone does not clock
    bus_wr(A_CTRL, 16'h0001);
    base = any_edges;
    repeat (20) @(posedge clk);
    peek(A_STAT, s);
    chk(any_edges == base, "R2 no edges without read", any_edges - base, 0);
    chk(s[2] == 1'b0, "R2 idle", s[2], 0);

    // table walk: R2 R3 R4 R5 R12
    for (int i = 0; i < 6; i++) begin
      logic [7:0] dv, bt;
      logic       pl;
      dv = VEC[i][19:12]; pl = VEC[i][11]; bt = VEC[i][7:0];
      bus_wr(A_CTRL, {dv, 5'b0, pl, 2'b01});
      pol_tb = pl;
      base = leads;
      start_frame(bt);
      wait_idle(c);
      slave_on = 1'b0;
      chk(c == 16 * (int'(dv) + 1), "R4 R12 frame length", c, 16 * (int'(dv) + 1));
      chk(leads - base == 8, "R4 sample edges", leads - base, 8);
      chk((first_lead_t - t_launch) == (int'(dv) + 1) * PERIOD, "R4 first edge",
          32'(first_lead_t - t_launch), (int'(dv) + 1) * PERIOD);
      peek(A_DATA, d); chk(d == {8'h0, bt}, "R3 byte", d, bt);
      peek(A_STAT, s); chk(s[0] == 1'b1, "R5 full set", s[0], 1);
      chk(sck == pl, "R3 idle level", sck, pl);
    end
    bus_rd(A_DATA, d);
    peek(A_STAT, s); chk(s[0] == 1'b0, "R5 read clears", s[0], 0);

    // R6 continuous, R7 stop
    bus_wr(A_CTRL, 16'h0101);
    pol_tb = 1'b0;
    tx_next = 8'h5A;
    start_frame(8'hC3);
    repeat (5) @(posedge clk);
    bus_rd(A_DATA, d);
    wait_stat_bit(0);
    peek(A_STAT, s); chk(s[2] == 1'b1, "R6 busy continues", s[2], 1);
    peek(A_DATA, d); chk(d[7:0] == 8'hC3, "R6 first byte", d, 8'hC3);
    bus_wr(A_CTRL, 16'h0103);
    bus_rd(A_DATA, d); chk(d[7:0] == 8'hC3, "R6 read first", d, 8'hC3);
    wait_idle(c);
    slave_on = 1'b0;
    peek(A_DATA, d); chk(d[7:0] == 8'h5A, "R6 second byte", d, 8'h5A);
    base = any_edges;
    repeat (20) @(posedge clk);
    peek(A_STAT, s); chk(s[2] == 1'b0, "R7 pending dropped", s[2], 0);
    bus_rd(A_DATA, d); chk(d[7:0] == 8'h5A, "R7 read", d, 8'h5A);
    repeat (20) @(posedge clk);
    peek(A_STAT, s); chk(s[2] == 1'b0, "R7 idle read no launch", s[2], 0);
    chk(any_edges == base, "R7 no edges", any_edges - base, 0);

    // R8 disabled final read
    bus_wr(A_CTRL, 16'h0001);
    start_frame(8'h7E);
    wait_idle(c);
    slave_on = 1'b0;
    bus_wr(A_CTRL, 16'h0000);
    base = any_edges;
    bus_rd(A_DATA, d); chk(d[7:0] == 8'h7E, "R8 final byte", d, 8'h7E);
    repeat (20) @(posedge clk);
    peek(A_STAT, s); chk(s[2:0] == 3'b000, "R8 no frame, full cleared", s, 0);
    chk(any_edges == base, "R8 no edges", any_edges - base, 0);

    // R9 overrun, R10 blocking
    bus_wr(A_CTRL, 16'h0001);
    tx_next = 8'h22;
    start_frame(8'h11);
    repeat (3) @(posedge clk);
    bus_rd(A_DATA, d);
    wait_stat_bit(1);
    slave_on = 1'b0;
    peek(A_STAT, s); chk(s[1:0] == 2'b11, "R9 overrun and full", s, 3);
    peek(A_DATA, d); chk(d[7:0] == 8'h11, "R9 kept byte", d, 8'h11);
    base = any_edges;
    bus_rd(A_DATA, d); chk(d[7:0] == 8'h11, "R10 read", d, 8'h11);
    repeat (20) @(posedge clk);
    peek(A_STAT, s); chk(s[2] == 1'b0, "R10 no launch", s[2], 0);
    chk(any_edges == base, "R10 no edges", any_edges - base, 0);

    // R11 clearing rules
    bus_wr(A_STAT, 16'h0002);
    peek(A_STAT, s); chk(s[1] == 1'b1, "R11 write one no effect", s[1], 1);
    bus_wr(A_DATA, 16'h00AA);
    peek(A_DATA, d); chk(d[7:0] == 8'h11, "R11 data write ignored", d, 8'h11);
    bus_wr(A_STAT, 16'h0000);
    peek(A_STAT, s); chk(s[1] == 1'b0, "R11 write zero clears", s[1], 0);
    start_frame(8'h99);
    peek(A_STAT, s); chk(s[2] == 1'b1, "R12 busy after launch", s[2], 1);
    wait_idle(c);
    slave_on = 1'b0;
    chk(c == 15, "R12 busy length", c, 15);
    peek(A_DATA, d); chk(d[7:0] == 8'h99, "R11 reception resumes", d, 8'h99);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule